// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Register Front End

This block is the digital side of a four-channel, 8-bit converter. A host drives one shared 8-bit data bus, a two-bit channel address, an active-low write strobe and a load control. Each channel has two storage stages. The first is an input latch, which the write strobe fills. The second is an output register, whose contents are the code that drives that channel's converter. The load control governs all four output registers together. While it is low they follow their input latches. While it is high they freeze. A host can therefore stage new codes in every input latch and release them to all outputs in a single cycle.

Both stages behave as level-sensitive latches but are built as synchronous storage on a fast system clock, which samples the strobes many times per bus cycle. A timing monitor runs on the same clock. It measures strobe widths, data setup and address hold in whole clock periods, using a parameter for the clock period in ns. Each kind of violation sets a sticky flag, and only reset clears the flags.

The monitor uses two small state machines. The write machine has the states WS_IDLE (strobe high), WS_STROBE (strobe low; counting low samples and data-stable samples) and WS_AFTER (strobe high again; address hold window still open). Its transitions are: WS_IDLE to WS_STROBE on a low strobe sample. WS_STROBE to WS_AFTER on the first high sample, or straight to WS_IDLE when the hold window is one sample. WS_AFTER to WS_STROBE on a new low sample. WS_AFTER to WS_IDLE when the window ends. The load machine has the states LS_ARM (after reset; waits for the first high level without judging the low level that reset left), LS_HIGH and LS_LOW. Its transitions are: LS_ARM to LS_HIGH on a high sample. LS_HIGH to LS_LOW on a low sample. LS_LOW to LS_HIGH on a high sample, where the low pulse is judged.

Top module: `quad_dac_frontend`

## Requirements
- R1: While `rst_n` is low, all four input latches, all four output codes and all three flags are 0.
- R2: Whenever a rising clock edge samples `wr_n` low, the input latch of the channel selected by `chan_sel` takes `bus_data` at that edge. Address 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel k appears on `code_out[8k+7:8k]`.
- R3: An edge that samples `wr_n` high changes no input latch. An edge that samples `wr_n` low changes only the addressed latch.
- R4: An edge that samples `load` low copies every input latch into its output register. A write made while `load` is low therefore reaches `code_out` at the second edge after the first low `wr_n` sample.
- R5: An edge that samples `load` high leaves `code_out` unchanged, whatever the write port does.
- R6: After channels are written while `load` is high, the first edge that samples `load` low updates all four outputs together.
- R7: `flag_setup` is set when a write strobe ends (the first high `wr_n` sample) and fewer than 5 consecutive final low samples carried the same `bus_data` (45 ns at a 10 ns clock).
- R8: `flag_width` is set when `wr_n` was low for fewer than 5 samples (50 ns).
- R9: `flag_width` is set when a low pulse on `load` that began after the first high level following reset lasted fewer than 5 samples.
- R10: `flag_hold` is set when `chan_sel` changes while `wr_n` is low, or on the first high sample. During a strobe, data still goes to the channel addressed at each sample.
- R11: Flags are sticky until reset. Traffic that meets every timing rule sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Shared data bus |
| chan_sel | input | 2 | Channel address (0 selects A, 3 selects D) |
| wr_n | input | 1 | Active-low write strobe; the addressed input latch follows the bus while it is low |
| load | input | 1 | Low: output registers follow the input latches; high: output registers hold |
| code_out | output | 32 | Four output codes, channel k in bits 8k+7..8k |
| flag_setup | output | 1 | Sticky data setup violation |
| flag_hold | output | 1 | Sticky address hold violation |
| flag_width | output | 1 | Sticky strobe or load pulse width violation |

## Verification
An input latch changes at the first edge that samples `wr_n` low. The matching output changes one edge later when `load` is low, or at the first edge that samples `load` low after a hold. The bench drives inputs on falling edges and reads `code_out` on falling edges, one or two edges after the stimulus. It checks the old value before the due edge and the new value after it. Flags are registered at the edge that samples the end of a strobe or pulse, and the bench reads them two falling edges later.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_STROBE = 2'd1,
        WS_AFTER  = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        LS_ARM  = 2'd0,
        LS_HIGH = 2'd1,
        LS_LOW  = 2'd2
    } ld_state_t;

    function automatic int unsigned ns_to_cycles(input int unsigned t_ns, input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/qdac_input_bank.sv
module qdac_input_bank #(
    parameter int DW = 8,
    parameter int AW = 2,
    localparam int NCH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [AW-1:0]     sel,
    input  logic [DW-1:0]     din,
    output logic [NCH*DW-1:0] lat_flat
);

    logic [DW-1:0] lat_q [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lat
        logic hit;
        assign hit = !wr_n && (sel == AW'(ch));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lat_q[ch] <= '0;
            end else if (hit) begin
                lat_q[ch] <= din;
            end
        end

        assign lat_flat[ch*DW +: DW] = lat_q[ch];
    end

endmodule

// File: rtl/qdac_output_bank.sv
module qdac_output_bank #(
    parameter int DW  = 8,
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NCH*DW-1:0] lat_flat,
    output logic [NCH*DW-1:0] code_flat
);

    logic [DW-1:0] out_q [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q[ch] <= '0;
            end else if (!load) begin
                out_q[ch] <= lat_flat[ch*DW +: DW];
            end
        end

        assign code_flat[ch*DW +: DW] = out_q[ch];
    end

endmodule

// File: rtl/qdac_wr_monitor.sv
module qdac_wr_monitor
    import qdac_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 2,
    parameter int SU_CYC = 5,
    parameter int WR_CYC = 5,
    parameter int HA_CYC = 1,
    localparam int MAXC  = (SU_CYC > WR_CYC) ? ((SU_CYC > HA_CYC) ? SU_CYC : HA_CYC)
                                             : ((WR_CYC > HA_CYC) ? WR_CYC : HA_CYC),
    localparam int CW    = $clog2(MAXC + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic [AW-1:0] sel,
    input  logic [DW-1:0] din,
    output logic          setup_err,
    output logic          hold_err,
    output logic          width_err
);

    wr_state_t st_q, st_nx;

    logic [CW-1:0] low_cnt_q;
    logic [CW-1:0] stab_cnt_q;
    logic [CW-1:0] aft_cnt_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == {CW{1'b1}}) ? v : v + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WS_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            WS_IDLE: begin
                if (!wr_n) st_nx = WS_STROBE;
            end
            WS_STROBE: begin
                if (wr_n) st_nx = (HA_CYC > 1) ? WS_AFTER : WS_IDLE;
            end
            WS_AFTER: begin
                if (!wr_n) begin
                    st_nx = WS_STROBE;
                end else if (aft_cnt_q >= CW'(HA_CYC - 1)) begin
                    st_nx = WS_IDLE;
                end
            end
            default: st_nx = WS_IDLE;
        endcase
    end

    // measurement counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q  <= '0;
            stab_cnt_q <= '0;
            aft_cnt_q  <= '0;
            addr_q     <= '0;
            data_q     <= '0;
        end else begin
            unique case (st_q)
                WS_IDLE, WS_AFTER: begin
                    if (!wr_n) begin
                        low_cnt_q  <= CW'(1);
                        stab_cnt_q <= CW'(1);
                        addr_q     <= sel;
                        data_q     <= din;
                    end else begin
                        aft_cnt_q <= sat_inc(aft_cnt_q);
                    end
                end
                WS_STROBE: begin
                    if (!wr_n) begin
                        low_cnt_q  <= sat_inc(low_cnt_q);
                        stab_cnt_q <= (din == data_q) ? sat_inc(stab_cnt_q) : CW'(1);
                        addr_q     <= sel;
                        data_q     <= din;
                    end else begin
                        aft_cnt_q <= CW'(1);
                    end
                end
                default: begin
                    low_cnt_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        setup_err = 1'b0;
        hold_err  = 1'b0;
        width_err = 1'b0;
        unique case (st_q)
            WS_IDLE: begin
                setup_err = 1'b0;
            end
            WS_STROBE: begin
                hold_err = (sel != addr_q);
                if (wr_n) begin
                    setup_err = (stab_cnt_q < CW'(SU_CYC));
                    width_err = (low_cnt_q  < CW'(WR_CYC));
                end
            end
            WS_AFTER: begin
                hold_err = wr_n && (sel != addr_q);
            end
            default: begin
                hold_err = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/qdac_ld_monitor.sv
module qdac_ld_monitor
    import qdac_pkg::*;
#(
    parameter int LD_CYC = 5,
    localparam int CW    = $clog2(LD_CYC + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic width_err
);

    ld_state_t st_q, st_nx;
    logic [CW-1:0] low_cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LS_ARM;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            LS_ARM:  if (load)  st_nx = LS_HIGH;
            LS_HIGH: if (!load) st_nx = LS_LOW;
            LS_LOW:  if (load)  st_nx = LS_HIGH;
            default: st_nx = LS_ARM;
        endcase
    end

    // low pulse length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (st_q == LS_HIGH && !load) begin
            low_cnt_q <= CW'(1);
        end else if (st_q == LS_LOW && !load && low_cnt_q != {CW{1'b1}}) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        width_err = 1'b0;
        unique case (st_q)
            LS_ARM:  width_err = 1'b0;
            LS_HIGH: width_err = 1'b0;
            LS_LOW:  width_err = load && (low_cnt_q < CW'(LD_CYC));
            default: width_err = 1'b0;
        endcase
    end

endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
    import qdac_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 2,
    parameter int CLK_NS   = 10,
    parameter int T_DSU_NS = 45,
    parameter int T_WRW_NS = 50,
    parameter int T_LDW_NS = 50,
    parameter int T_AH_NS  = 10,
    localparam int NCH     = 1 << AW,
    localparam int SU_CYC  = int'(ns_to_cycles(T_DSU_NS, CLK_NS)),
    localparam int WR_CYC  = int'(ns_to_cycles(T_WRW_NS, CLK_NS)),
    localparam int LD_CYC  = int'(ns_to_cycles(T_LDW_NS, CLK_NS)),
    localparam int HA_CYC  = int'(ns_to_cycles(T_AH_NS, CLK_NS))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     bus_data,
    input  logic [AW-1:0]     chan_sel,
    input  logic              wr_n,
    input  logic              load,
    output logic [NCH*DW-1:0] code_out,
    output logic              flag_setup,
    output logic              flag_hold,
    output logic              flag_width
);

    logic [NCH*DW-1:0] lat_flat;
    logic wr_setup_err, wr_hold_err, wr_width_err, ld_width_err;

    qdac_input_bank #(.DW(DW), .AW(AW)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .sel      (chan_sel),
        .din      (bus_data),
        .lat_flat (lat_flat)
    );

    qdac_output_bank #(.DW(DW), .NCH(NCH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .lat_flat  (lat_flat),
        .code_flat (code_out)
    );

    qdac_wr_monitor #(
        .DW(DW), .AW(AW), .SU_CYC(SU_CYC), .WR_CYC(WR_CYC), .HA_CYC(HA_CYC)
    ) u_wmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_n      (wr_n),
        .sel       (chan_sel),
        .din       (bus_data),
        .setup_err (wr_setup_err),
        .hold_err  (wr_hold_err),
        .width_err (wr_width_err)
    );

    qdac_ld_monitor #(.LD_CYC(LD_CYC)) u_lmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .width_err (ld_width_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_setup <= 1'b0;
            flag_hold  <= 1'b0;
            flag_width <= 1'b0;
        end else begin
            flag_setup <= flag_setup | wr_setup_err;
            flag_hold  <= flag_hold  | wr_hold_err;
            flag_width <= flag_width | wr_width_err | ld_width_err;
        end
    end

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
    parameter int DW  = 8,
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_n,
    input logic              load,
    input logic [NCH*DW-1:0] code_out,
    input logic [NCH*DW-1:0] lat_bus,
    input logic              flag_setup,
    input logic              flag_hold,
    input logic              flag_width
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (code_out == '0 && lat_bus == '0 && !flag_setup && !flag_hold && !flag_width)); // R1

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(lat_bus)); // R3

    AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (code_out == $past(lat_bus))); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> $stable(code_out)); // R5

    AST_SETUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_setup |=> flag_setup); // R11

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hold |=> flag_hold); // R11

    AST_WIDTH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_width |=> flag_width); // R11

endmodule

bind quad_dac_frontend qdac_checker #(.DW(DW), .NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_n       (wr_n),
    .load       (load),
    .code_out   (code_out),
    .lat_bus    (lat_flat),
    .flag_setup (flag_setup),
    .flag_hold  (flag_hold),
    .flag_width (flag_width)
);

// File: tb/tb_quad_dac_frontend.sv
module tb_quad_dac_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int LOWS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = '0;
    logic [1:0]  chan_sel = '0;
    logic        wr_n = 1'b1;
    logic        load = 1'b0;
    logic [31:0] code_out;
    logic        flag_setup, flag_hold, flag_width;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] lat_m [4];
    logic [7:0] out_m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_dac_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .chan_sel(chan_sel),
        .wr_n(wr_n), .load(load), .code_out(code_out),
        .flag_setup(flag_setup), .flag_hold(flag_hold), .flag_width(flag_width)
    );

    function automatic logic [7:0] code_of(input int ch);
        return code_out[ch*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < 4; c++) chk(req, {24'h0, code_of(c)}, {24'h0, out_m[c]});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; load = 1'b0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 4; c++) begin lat_m[c] = '0; out_m[c] = '0; end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // legal write with n_low strobe samples; model updates per requirements
    task automatic write_ch(input int ch, input logic [7:0] d, input int n_low);
        @(negedge clk);
        chan_sel = 2'(ch); bus_data = d; wr_n = 1'b0;
        repeat (n_low) @(negedge clk);
        wr_n = 1'b1;
        lat_m[ch] = d;
        if (!load) out_m[ch] = d;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0C1A));
        for (int c = 0; c < 4; c++) begin lat_m[c] = '0; out_m[c] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 code", code_out, 32'h0);
        chk("R1 flags", {29'h0, flag_setup, flag_hold, flag_width}, 32'h0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R2/R4: latency with transparent output stage, channel B
        chan_sel = 2'd1; bus_data = 8'hA7; wr_n = 1'b0;
        @(negedge clk);
        chk("R4 not yet", {24'h0, code_of(1)}, 32'h0);
        @(negedge clk);
        chk("R2 R4 chB due", {24'h0, code_of(1)}, 32'hA7);
        chk("R3 chA untouched", {24'h0, code_of(0)}, 32'h0);
        repeat (LOWS - 2) @(negedge clk);
        wr_n = 1'b1; lat_m[1] = 8'hA7; out_m[1] = 8'hA7;
        repeat (2) @(negedge clk);

        // R2: address map, every channel
        write_ch(0, 8'h11, LOWS); write_ch(2, 8'h33, LOWS); write_ch(3, 8'hFF, LOWS);
        repeat (3) @(negedge clk);
        chk_all("R2 map");

        // R3: strobe high, bus and address toggling, nothing changes
        chan_sel = 2'd2; bus_data = 8'h00;
        repeat (3) @(negedge clk);
        bus_data = 8'h5C;
        repeat (3) @(negedge clk);
        chk_all("R3 idle bus");

        // random traffic
        for (int it = 0; it < 60; it++) begin
            if ($urandom % 2 == 0) begin
                write_ch(int'($urandom % 4), 8'($urandom), LOWS + int'($urandom % 3));
                repeat (2) @(negedge clk);
                chk_all("R4 follow");
            end else begin
                load = 1'b1;
                repeat (2) @(negedge clk);
                for (int k = 0; k < 1 + int'($urandom % 4); k++)
                    write_ch(int'($urandom % 4), 8'($urandom), LOWS);
                repeat (2) @(negedge clk);
                chk_all("R5 hold");
                load = 1'b0;
                @(negedge clk);
                for (int c = 0; c < 4; c++) out_m[c] = lat_m[c];
                chk_all("R6 together");
                repeat (LOWS) @(negedge clk);
            end
        end
        chk("R11 clean traffic", {29'h0, flag_setup, flag_hold, flag_width}, 32'h0);

        // R6 directed: all four staged, released on one edge
        load = 1'b1;
        @(negedge clk);
        write_ch(0, 8'h01, LOWS); write_ch(1, 8'h02, LOWS);
        write_ch(2, 8'h03, LOWS); write_ch(3, 8'h04, LOWS);
        @(negedge clk);
        load = 1'b0;
        chk("R6 before release", {24'h0, code_of(3)}, {24'h0, out_m[3]});
        @(negedge clk);
        chk("R6 released", code_out, 32'h04030201);
        repeat (LOWS) @(negedge clk);

        // R1: reset clears a populated state
        do_reset();
        chk("R1 after traffic", code_out, 32'h0);

        // R8: short write strobe
        write_ch(0, 8'h22, 3);
        repeat (2) @(negedge clk);
        chk("R8 width", {31'h0, flag_width}, 32'h1);
        chk("R10 no hold", {31'h0, flag_hold}, 32'h0);

        // R7: data changes on the final low sample
        do_reset();
        chan_sel = 2'd1; bus_data = 8'h40; wr_n = 1'b0;
        repeat (LOWS - 1) @(negedge clk);
        bus_data = 8'h41;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 setup", {31'h0, flag_setup}, 32'h1);
        chk("R8 width ok", {31'h0, flag_width}, 32'h0);
        repeat (10) @(negedge clk);
        chk("R11 sticky", {31'h0, flag_setup}, 32'h1);

        // R10: address moves mid-strobe; data follows the new address
        do_reset();
        chan_sel = 2'd0; bus_data = 8'h5A; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chan_sel = 2'd2;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 hold mid", {31'h0, flag_hold}, 32'h1);
        chk("R10 steered C", {24'h0, code_of(2)}, 32'h5A);
        chk("R7 no setup", {31'h0, flag_setup}, 32'h0);

        // R10: address moves with the strobe's rise
        do_reset();
        chan_sel = 2'd3; bus_data = 8'h77; wr_n = 1'b0;
        repeat (LOWS) @(negedge clk);
        wr_n = 1'b1; chan_sel = 2'd0;
        repeat (2) @(negedge clk);
        chk("R10 hold rise", {31'h0, flag_hold}, 32'h1);

        // R9: short load low pulse
        do_reset();
        load = 1'b1;
        repeat (3) @(negedge clk);
        load = 1'b0;
        repeat (2) @(negedge clk);
        load = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 load width", {31'h0, flag_width}, 32'h1);
        chk("R9 others clear", {30'h0, flag_setup, flag_hold}, 32'h0);

        finish_run();
    end

endmodule